// File: doc/BRIEF.md
# Misaligned Access Splitter with Region Wrap

This unit sits between the data port of a processor and a memory bus that only carries naturally aligned transfers. It takes one byte, halfword or word request at a time. A request that is already aligned goes out as one bus access. A misaligned request becomes a short sequence of aligned pieces, two or three of them. For a write, each piece carries the write data and strobes for its byte lanes. For a read, the bytes that each piece returns are collected into one little-endian result.

The address space is divided into regions of 2^REGION_BITS bytes. When a piece would step past the end of the region that holds the request, its address wraps to the base of that same region and does not move into the next one. While a sequence is in progress, the unit refuses further requests. A bus error on any piece is reported with the response.

Top module: `usplit_top`

## Requirements
- R1: `req_size` encodes the transfer as follows: 00 is a byte, 01 a halfword, 10 a word, and 11 is treated as a word. An aligned request produces exactly one bus access with the same address and size. Its response is asserted in the same cycle as that access's `bus_ack`.
- R2: A halfword at an odd address A is issued as a byte at A, then a byte at A+1.
- R3: A word at an address with low bits 10 is issued as a halfword at A, then a halfword at A+2.
- R4: A word at an address with low bits 01 or 11 is issued as a byte at A, then a halfword at A+1, then a byte at A+3.
- R5: Piece addresses keep the upper ADDR_W-REGION_BITS bits of the request address, and the low bits wrap modulo 2^REGION_BITS. With the default parameters, a halfword at 0x1FFFFFFF goes to 0x1FFFFFFF and then 0x00000000, and a halfword at 0x3FFFFFFF goes to 0x3FFFFFFF and then 0x20000000.
- R6: `bus_strb` bit i marks byte lane i, which is `bus_addr[1:0]` upward for the piece size. Request write byte k (bits 8k+7:8k) appears on the lane that holds request address A+k.
- R7: Read data is little-endian: the byte from A+k lands in `rsp_rdata[8k+7:8k]`, and unused upper bytes read as zero. `rsp_valid` is asserted only with the `bus_ack` of the final piece.
- R8: `req_ready` is low from the cycle after acceptance until the cycle after the response, so a held request waits for the whole sequence. `bus_valid` holds its address and strobes steady until `bus_ack`.
- R9: If any piece returns `bus_err`, the response carries `rsp_err`. A write stops at the failing piece, abandons the remaining pieces and responds in that cycle. A read issues all of its pieces and reports the error at the end.
- R10: After reset, `req_ready` is 1, and `bus_valid` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when high |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 2 | Transfer size code |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data, little-endian from the address |
| rsp_valid | output | 1 | Request completed |
| rsp_rdata | output | 32 | Assembled read data |
| rsp_err | output | 1 | Some piece reported an error |
| bus_valid | output | 1 | Aligned piece on the bus |
| bus_addr | output | ADDR_W | Piece address |
| bus_size | output | 2 | Piece size code |
| bus_write | output | 1 | Piece direction |
| bus_strb | output | 4 | Byte lanes of the piece |
| bus_wdata | output | 32 | Lane-positioned write data |
| bus_ack | input | 1 | Piece completed this cycle |
| bus_rdata | input | 32 | Read data for the piece, full word lanes |
| bus_err | input | 1 | Piece failed |

## Verification
The bench builds the block with ADDR_W=32 and REGION_BITS=29, which places region edges at 0x1FFFFFFF/0x00000000 and at 0x3FFFFFFF/0x20000000. These values bring the wrap of each piece shape within reach, and they make the wrap land on a read-only area at the bottom of memory, where the memory model refuses writes. The memory model can also stall each piece by a programmable number of cycles, which exercises the hold and stall behaviour. It can inject an error on a chosen word, which shows the different error handling for reads and writes.

// File: rtl/usplit_pkg.sv
`timescale 1ns/1ps
package usplit_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } xfer_size_e;

    typedef struct packed {
        logic [LANE_W-1:0] off;    // byte offset of the piece inside the request
        xfer_size_e        psize;  // aligned piece size
        logic              last;   // final piece of the sequence
    } piece_t;

    function automatic logic [LANES-1:0] size_mask(xfer_size_e s);
        case (s)
            SZ_BYTE: size_mask = 4'b0001;
            SZ_HALF: size_mask = 4'b0011;
            default: size_mask = 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/usplit_plan.sv
`timescale 1ns/1ps
module usplit_plan
    import usplit_pkg::*;
(
    input  logic [LANE_W-1:0] lo,
    input  xfer_size_e        size,
    input  logic [1:0]        idx,
    output piece_t            piece
);

    always_comb begin
        piece = '{off: '0, psize: SZ_BYTE, last: 1'b1};
        case (size)
            SZ_BYTE: piece = '{off: 2'd0, psize: SZ_BYTE, last: 1'b1};
            SZ_HALF: begin
                if (!lo[0]) begin
                    piece = '{off: 2'd0, psize: SZ_HALF, last: 1'b1};
                end else if (idx == 2'd0) begin
                    piece = '{off: 2'd0, psize: SZ_BYTE, last: 1'b0};
                end else begin
                    piece = '{off: 2'd1, psize: SZ_BYTE, last: 1'b1};
                end
            end
            default: begin
                if (lo == 2'b00) begin
                    piece = '{off: 2'd0, psize: SZ_WORD, last: 1'b1};
                end else if (lo == 2'b10) begin
                    if (idx == 2'd0) piece = '{off: 2'd0, psize: SZ_HALF, last: 1'b0};
                    else             piece = '{off: 2'd2, psize: SZ_HALF, last: 1'b1};
                end else begin
                    case (idx)
                        2'd0:    piece = '{off: 2'd0, psize: SZ_BYTE, last: 1'b0};
                        2'd1:    piece = '{off: 2'd1, psize: SZ_HALF, last: 1'b0};
                        default: piece = '{off: 2'd3, psize: SZ_BYTE, last: 1'b1};
                    endcase
                end
            end
        endcase
    end

endmodule

// File: rtl/usplit_lane.sv
`timescale 1ns/1ps
module usplit_lane
    import usplit_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int REGION_BITS = 29
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LANE_W-1:0] off,
    input  xfer_size_e        psize,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] piece_addr,
    output logic [LANES-1:0]  strb,
    output logic [DATA_W-1:0] lane_wdata,
    output logic [DATA_W-1:0] rd_part
);

    logic [REGION_BITS-1:0] low_sum;
    logic [LANE_W-1:0]      lane;
    logic [LANES-1:0]       bmask;
    logic [DATA_W-1:0]      bmask_bits;

    assign low_sum = base_addr[REGION_BITS-1:0] + REGION_BITS'(off);

    if (REGION_BITS < ADDR_W) begin : g_keep_region
        assign piece_addr = {base_addr[ADDR_W-1:REGION_BITS], low_sum};
    end else begin : g_flat_space
        assign piece_addr = low_sum;
    end

    assign lane  = piece_addr[LANE_W-1:0];
    assign bmask = size_mask(psize);

    for (genvar i = 0; i < LANES; i++) begin : g_bits
        assign bmask_bits[8*i +: 8] = {8{bmask[i]}};
    end

    assign strb       = bmask << lane;
    assign lane_wdata = (wdata >> {off, 3'b000}) << {lane, 3'b000};
    assign rd_part    = ((bus_rdata >> {lane, 3'b000}) & bmask_bits) << {off, 3'b000};

endmodule

// File: rtl/usplit_top.sv
`timescale 1ns/1ps
module usplit_top
    import usplit_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int REGION_BITS = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic              bus_write,
    output logic [3:0]        bus_strb,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_err
);

    typedef struct packed {
        logic              busy;
        logic [1:0]        idx;
        logic [ADDR_W-1:0] addr;
        xfer_size_e        size;
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] acc;
        logic              err;
    } state_t;

    state_t            st_d, st_q;
    piece_t            piece;
    logic [DATA_W-1:0] rd_part;
    logic              finish;

    usplit_plan u_plan (
        .lo    (st_q.addr[LANE_W-1:0]),
        .size  (st_q.size),
        .idx   (st_q.idx),
        .piece (piece)
    );

    usplit_lane #(
        .ADDR_W      (ADDR_W),
        .REGION_BITS (REGION_BITS)
    ) u_lane (
        .base_addr  (st_q.addr),
        .off        (piece.off),
        .psize      (piece.psize),
        .wdata      (st_q.wdata),
        .bus_rdata  (bus_rdata),
        .piece_addr (bus_addr),
        .strb       (bus_strb),
        .lane_wdata (bus_wdata),
        .rd_part    (rd_part)
    );

    assign finish    = piece.last || (st_q.write && bus_err);
    assign req_ready = !st_q.busy;
    assign bus_valid = st_q.busy;
    assign bus_size  = piece.psize;
    assign bus_write = st_q.write;
    assign rsp_err   = rsp_valid && (st_q.err || bus_err);
    assign rsp_rdata = (rsp_valid && !st_q.write) ? (st_q.acc | rd_part) : '0;

    always_comb begin
        st_d      = st_q;
        rsp_valid = 1'b0;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy  = 1'b1;
                st_d.idx   = '0;
                st_d.addr  = req_addr;
                st_d.size  = xfer_size_e'(req_size);
                st_d.write = req_write;
                st_d.wdata = req_wdata;
                st_d.acc   = '0;
                st_d.err   = 1'b0;
            end
        end else if (bus_ack) begin
            if (finish) begin
                st_d.busy = 1'b0;
                rsp_valid = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 2'd1;
                st_d.acc = st_q.acc | rd_part;
                st_d.err = st_q.err | bus_err;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, idx: '0, addr: '0, size: SZ_BYTE, write: 1'b0,
                      wdata: '0, acc: '0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // R1: every piece on the bus is naturally aligned
    assert_piece_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> ((bus_size == 2'b00) ||
                       (bus_size == 2'b01 && !bus_addr[0]) ||
                       (bus_addr[1:0] == 2'b00)));

    // R5: a piece never leaves the region of its request
    assert_same_region_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> ((bus_addr >> REGION_BITS) == (st_q.addr >> REGION_BITS)));

    // R6: strobe count matches the piece size
    assert_strb_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> ($countones(bus_strb) ==
                       ((bus_size == 2'b00) ? 1 : (bus_size == 2'b01) ? 2 : 4)));

    // R7: a response only comes with a bus completion
    assert_rsp_with_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (bus_valid && bus_ack));

    // R8: an unacknowledged piece stays put
    assert_piece_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_addr) && $stable(bus_strb)));

    // R8: an accepted request reaches the bus on the next cycle
    assert_accept_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> bus_valid);

    // R9: a failing write piece ends the sequence at once
    assert_write_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ack && bus_err && bus_write) |-> (rsp_valid && rsp_err));

endmodule

// File: tb/usplit_top_tb.sv
`timescale 1ns/1ps
module usplit_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        bus_valid;
    logic [31:0] bus_addr;
    logic [1:0]  bus_size;
    logic        bus_write;
    logic [3:0]  bus_strb;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        bus_err = 1'b0;

    always #2.5 clk = ~clk;

    usplit_top #(.ADDR_W(32), .REGION_BITS(29)) u_dut (
        .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_size, .req_write,
        .req_wdata, .rsp_valid, .rsp_rdata, .rsp_err, .bus_valid, .bus_addr,
        .bus_size, .bus_write, .bus_strb, .bus_wdata, .bus_ack, .bus_rdata, .bus_err
    );

    int total = 0;
    int bad   = 0;

    logic [7:0]  mem [logic [31:0]];
    int          lat = 0;
    int          wcnt = 0;
    logic        err_on = 1'b0;
    logic [31:0] err_word = '0;

    logic [31:0] log_a [8];
    logic [1:0]  log_s [8];
    logic [3:0]  log_b [8];
    logic [31:0] log_w [8];
    int          n_log = 0;
    logic [31:0] rsp_d [4];
    logic        rsp_e [4];
    int          rsp_n [4];
    int          rsp_cnt = 0;
    int          stall_bad = 0;

    function automatic logic [7:0] patt(input logic [31:0] a);
        return a[7:0] ^ {a[31:29], 5'b0} ^ 8'h3C;
    endfunction

    function automatic logic [7:0] mem_rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return patt(a);
    endfunction

    function automatic logic [31:0] smask(input logic [3:0] s);
        return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    endfunction

    // memory model: answers after lat wait cycles, boot area below 0x100 is read-only
    initial begin
        forever begin
            @(negedge clk);
            if (bus_valid && wcnt >= lat) begin
                bus_ack = 1'b1;
                bus_err = (bus_write && bus_addr[31:8] == 24'h0) ||
                          (err_on && bus_addr[31:2] == err_word[31:2]);
                for (int l = 0; l < 4; l++) begin
                    bus_rdata[8*l +: 8] = mem_rd({bus_addr[31:2], 2'b00} + l);
                    if (bus_write && !bus_err && bus_strb[l])
                        mem[{bus_addr[31:2], 2'b00} + l] = bus_wdata[8*l +: 8];
                end
                if (n_log < 8) begin
                    log_a[n_log] = bus_addr;
                    log_s[n_log] = bus_size;
                    log_b[n_log] = bus_strb;
                    log_w[n_log] = bus_wdata;
                end
                n_log++;
                wcnt = 0;
            end else begin
                bus_ack = 1'b0;
                bus_err = 1'b0;
                if (bus_valid) wcnt++;
                else wcnt = 0;
            end
            #1;
            if (bus_valid && req_ready) stall_bad++;
            if (rsp_valid) begin
                if (rsp_cnt < 4) begin
                    rsp_d[rsp_cnt] = rsp_rdata;
                    rsp_e[rsp_cnt] = rsp_err;
                    rsp_n[rsp_cnt] = n_log;
                end
                rsp_cnt++;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                       input logic [31:0] wd, input int l);
        lat = l;
        n_log = 0;
        rsp_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (rsp_cnt == 0) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R10 req_ready", 32'(req_ready), 32'd1);
        chk("R10 bus_valid", 32'(bus_valid), 32'd0);
        chk("R10 rsp_valid", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_aligned;
        run(32'h2000_0100, 2'b10, 1'b0, '0, 0);
        chk("R1 word count", 32'(n_log), 32'd1);
        chk("R1 word addr", log_a[0], 32'h2000_0100);
        chk("R1 word size", 32'(log_s[0]), 32'd2);
        chk("R1 response with ack", 32'(rsp_n[0]), 32'd1);
        chk("R7 word data", rsp_d[0], {patt(32'h2000_0103), patt(32'h2000_0102),
                                       patt(32'h2000_0101), patt(32'h2000_0100)});
        run(32'h2000_0203, 2'b00, 1'b1, 32'h0000_00EE, 2);
        chk("R1 byte count", 32'(n_log), 32'd1);
        chk("R6 byte strobe", 32'(log_b[0]), 32'h8);
        chk("R6 byte lane", log_w[0] & smask(log_b[0]), 32'hEE00_0000);
        run(32'h2000_0300, 2'b11, 1'b0, '0, 1);
        chk("R1 code 11 as word", 32'(log_s[0]), 32'd2);
    endtask

    task automatic t_half_odd;
        run(32'h2000_0011, 2'b01, 1'b0, '0, 1);
        chk("R2 count", 32'(n_log), 32'd2);
        chk("R2 first", log_a[0], 32'h2000_0011);
        chk("R2 second", log_a[1], 32'h2000_0012);
        chk("R2 sizes", {log_s[0], log_s[1]}, 32'h0);
        chk("R7 only after last", 32'(rsp_n[0]), 32'd2);
        chk("R7 half data", rsp_d[0], {16'h0, patt(32'h2000_0012), patt(32'h2000_0011)});
    endtask

    task automatic t_word_half;
        run(32'h2000_0022, 2'b10, 1'b1, 32'hA1B2_C3D4, 0);
        chk("R3 count", 32'(n_log), 32'd2);
        chk("R3 first", log_a[0], 32'h2000_0022);
        chk("R3 second", log_a[1], 32'h2000_0024);
        chk("R6 strobes", {log_b[0], log_b[1]}, 32'hC3);
        chk("R6 upper lanes", log_w[0] & smask(log_b[0]), 32'hC3D4_0000);
        chk("R6 lower lanes", log_w[1] & smask(log_b[1]), 32'h0000_A1B2);
        run(32'h2000_0022, 2'b10, 1'b0, '0, 1);
        chk("R7 readback", rsp_d[0], 32'hA1B2_C3D4);
    endtask

    task automatic t_word_odd;
        run(32'h2000_0031, 2'b10, 1'b0, '0, 0);
        chk("R4 count 01", 32'(n_log), 32'd3);
        chk("R4 addrs 01", {log_a[0][7:0], log_a[1][7:0], log_a[2][7:0]}, 32'h31_32_34);
        chk("R4 sizes 01", {log_s[0], log_s[1], log_s[2]}, 32'b00_01_00);
        chk("R7 data 01", rsp_d[0], {patt(32'h2000_0034), patt(32'h2000_0033),
                                     patt(32'h2000_0032), patt(32'h2000_0031)});
        run(32'h2000_0043, 2'b10, 1'b1, 32'h1122_3344, 1);
        chk("R4 addrs 11", {log_a[0][7:0], log_a[1][7:0], log_a[2][7:0]}, 32'h43_44_46);
        chk("R6 strobes 11", {log_b[0], log_b[1], log_b[2]}, 32'h834);
        chk("R6 lanes 11", (log_w[0] & smask(log_b[0])) | (log_w[1] & smask(log_b[1])) |
                           (log_w[2] & smask(log_b[2])), 32'h4411_2233);
        run(32'h2000_0043, 2'b10, 1'b0, '0, 0);
        chk("R7 readback 11", rsp_d[0], 32'h1122_3344);
    endtask

    task automatic t_wrap;
        run(32'h3FFF_FFFF, 2'b01, 1'b0, '0, 0);
        chk("R5 region1 first", log_a[0], 32'h3FFF_FFFF);
        chk("R5 region1 wrap", log_a[1], 32'h2000_0000);
        chk("R5 region1 data", rsp_d[0], {16'h0, patt(32'h2000_0000), patt(32'h3FFF_FFFF)});
        run(32'h1FFF_FFFE, 2'b10, 1'b0, '0, 1);
        chk("R5 word wrap first", log_a[0], 32'h1FFF_FFFE);
        chk("R5 word wrap second", log_a[1], 32'h0000_0000);
        chk("R5 word wrap data", rsp_d[0], {patt(32'h1), patt(32'h0),
                                            patt(32'h1FFF_FFFF), patt(32'h1FFF_FFFE)});
    endtask

    task automatic t_errors;
        run(32'h1FFF_FFFF, 2'b01, 1'b1, 32'h0000_7788, 0);
        chk("R5 boot wrap addr", log_a[1], 32'h0000_0000);
        chk("R9 boot write err", 32'(rsp_e[0]), 32'd1);
        run(32'h1FFF_FFFF, 2'b00, 1'b0, '0, 0);
        chk("R6 first byte landed", rsp_d[0], 32'h0000_0088);
        chk("R9 boot byte intact", 32'(mem_rd(32'h0)), 32'(patt(32'h0)));
        run(32'h0000_0001, 2'b10, 1'b1, 32'h0102_0304, 0);
        chk("R9 write abandoned", 32'(n_log), 32'd1);
        chk("R9 write err", 32'(rsp_e[0]), 32'd1);
        err_on = 1'b1;
        err_word = 32'h2000_0050;
        run(32'h2000_0051, 2'b10, 1'b0, '0, 0);
        err_on = 1'b0;
        chk("R9 read runs on", 32'(n_log), 32'd3);
        chk("R9 read err", 32'(rsp_e[0]), 32'd1);
        chk("R9 read err at end", 32'(rsp_n[0]), 32'd3);
        run(32'h2000_0051, 2'b10, 1'b0, '0, 0);
        chk("R9 clean after err", 32'(rsp_e[0]), 32'd0);
    endtask

    task automatic t_stall;
        lat = 2;
        n_log = 0;
        rsp_cnt = 0;
        stall_bad = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h2000_0061; req_size = 2'b01; req_write = 1'b0;
        @(negedge clk);
        req_addr = 32'h2000_0070; req_size = 2'b10;
        while (rsp_cnt < 1) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (rsp_cnt < 2) @(negedge clk);
        chk("R8 held request waits", 32'(stall_bad), 32'd0);
        chk("R8 total pieces", 32'(n_log), 32'd3);
        chk("R8 order", log_a[2], 32'h2000_0070);
        chk("R8 first data", rsp_d[0], {16'h0, patt(32'h2000_0062), patt(32'h2000_0061)});
        chk("R8 second data", rsp_d[1], {patt(32'h2000_0073), patt(32'h2000_0072),
                                         patt(32'h2000_0071), patt(32'h2000_0070)});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_aligned();
        t_half_odd();
        t_word_half();
        t_word_odd();
        t_wrap();
        t_errors();
        t_stall();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule